// File: doc/BRIEF.md
# Instruction Prefetch Counter and Queue

This block sits between program memory and the instruction decoder. It keeps a fetch counter that addresses program memory. It issues reads of two 16-bit words at even word addresses. The returned words go into an eight-entry queue, and the decoder takes them oldest first, one word at a time, each word labelled with its word address. Instruction-length decoding happens downstream.

A redirect loads a new target address. A flush restarts fetching at the oldest word the decoder has not yet taken. Either event empties the queue at once. Each one also advances a small sequence tag, so a read already in flight to memory is recognised by its stale tag when it returns and is dropped. When a redirect lands on an odd word address, the block first makes one single-word read at that address. It then steps to the next even address and goes back to double-word reads.

Top module: `ifetch_prefetch`

## Requirements
- R1: While `rst` is high, no request is made and `dec_valid_o` is low. On the first cycle after reset the fetch address is `RESET_ADDR` (0 by default) and the queue is empty.
- R2: When the fetch counter is even, `mem_addr_o` shows it with `mem_wide_o`=1. An accepted request (`mem_req_o` and `mem_ready_i` high together) advances the counter by 2.
- R3: When the fetch counter is odd, the request is narrow (`mem_wide_o`=0). Once accepted, the counter advances by 1 to an even address and wide reads follow.
- R4: A request is raised only when the words held plus the words still in flight, plus the words this request brings (2 wide, 1 narrow), do not exceed 8. A full queue stops fetching.
- R5: A redirect or a flush empties the queue: `dec_valid_o` is low in the next cycle.
- R6: A response whose `mem_rtag_i` differs from the tag current when it arrives, or that arrives in a redirect or flush cycle, puts nothing into the queue.
- R7: In a wide response, bits 15:0 carry the word at the lower (even) address and enter the queue before bits 31:16. A narrow response carries its word in bits 15:0, and bits 31:16 are ignored.
- R8: `dec_word_o`/`dec_addr_o` show the oldest queued word and its address while `dec_valid_o` is high. A cycle with `dec_take_i` and `dec_valid_o` high removes it, and the next word's address is one higher.
- R9: After a flush, fetching resumes at the address of the oldest word not taken by the decoder, and delivery to the decoder continues from that address.
- R10: In a redirect or flush cycle no request is raised and `dec_take_i` is ignored. When both are high, the redirect wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_i | input | 1 | Load a new fetch target and empty the queue |
| redirect_addr_i | input | ADDR_W | Redirect target word address |
| flush_i | input | 1 | Empty the queue and refetch from the oldest untaken word |
| mem_req_o | output | 1 | Read request to program memory |
| mem_addr_o | output | ADDR_W | Fetch word address (fetch counter) |
| mem_wide_o | output | 1 | 1: two-word read, 0: one-word read |
| mem_tag_o | output | TAG_W | Sequence tag sent with the request |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 2*WORD_W | Read data, lower address in the low half |
| mem_rtag_i | input | TAG_W | Tag returned with the read data |
| dec_valid_o | output | 1 | Queue holds at least one word |
| dec_word_o | output | WORD_W | Oldest queued word |
| dec_addr_o | output | ADDR_W | Word address of `dec_word_o` |
| dec_take_i | input | 1 | Decoder takes the oldest word |

## Verification
A fetch counter that has drifted shows up as a wrong `mem_addr_o` or `mem_wide_o` on the very next accepted request, before any data returns. A wrong occupancy or in-flight count shows up as `mem_req_o` high or low in the wrong cycle, or as `dec_valid_o` disagreeing with a count of words delivered and taken. A stale tag that slips through, or a swapped half of a wide response, gives a wrong `dec_word_o` once that word reaches the head. That is a few cycles later, when the decoder takes it.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int DEF_ADDR_W = 22;
    localparam int DEF_WORD_W = 16;
    localparam int DEF_QDEPTH = 8;
    localparam int DEF_TAG_W  = 3;

    typedef enum logic {
        FETCH_NARROW = 1'b0,
        FETCH_WIDE   = 1'b1
    } fwidth_e;

    typedef enum logic [1:0] {
        DISC_NONE     = 2'd0,
        DISC_FLUSH    = 2'd1,
        DISC_REDIRECT = 2'd2
    } disc_e;

    function automatic fwidth_e width_for(input logic addr_lsb);
        return addr_lsb ? FETCH_NARROW : FETCH_WIDE;
    endfunction

    function automatic int unsigned words_of(input fwidth_e w);
        return (w == FETCH_WIDE) ? 2 : 1;
    endfunction

    function automatic disc_e classify(input logic redirect, input logic flush);
        if (redirect) return DISC_REDIRECT;
        if (flush)    return DISC_FLUSH;
        return DISC_NONE;
    endfunction

endpackage

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int QDEPTH     = DEF_QDEPTH,
    parameter int TAG_W      = DEF_TAG_W,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W     = $clog2(QDEPTH + 1),
    localparam int SUM_W     = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  disc_e             disc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] resume_i,
    input  logic [CNT_W-1:0]  q_count_i,
    input  logic [CNT_W-1:0]  ret_words_i,
    input  logic              mem_ready_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_wide_o,
    output logic [TAG_W-1:0]  epoch_o,
    output logic [CNT_W-1:0]  pend_o
);

    logic [ADDR_W-1:0] fc_q;
    logic [TAG_W-1:0]  epoch_q;
    logic [CNT_W-1:0]  pend_q;
    fwidth_e           width;
    logic [SUM_W-1:0]  need;
    logic [SUM_W-1:0]  claim;
    logic              fits;
    logic              accept;

    assign width  = width_for(fc_q[0]);
    assign need   = SUM_W'(words_of(width));
    assign claim  = SUM_W'(q_count_i) + SUM_W'(pend_q) + need;
    assign fits   = claim <= SUM_W'(QDEPTH);

    assign mem_req_o  = !rst && (disc_i == DISC_NONE) && fits;
    assign accept     = mem_req_o && mem_ready_i;
    assign mem_addr_o = fc_q;
    assign mem_wide_o = (width == FETCH_WIDE);
    assign epoch_o    = epoch_q;
    assign pend_o     = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q    <= RESET_ADDR;
            epoch_q <= '0;
            pend_q  <= '0;
        end else begin
            unique case (disc_i)
                DISC_REDIRECT: begin
                    fc_q    <= target_i;
                    epoch_q <= epoch_q + 1'b1;
                    pend_q  <= '0;
                end
                DISC_FLUSH: begin
                    fc_q    <= resume_i;
                    epoch_q <= epoch_q + 1'b1;
                    pend_q  <= '0;
                end
                default: begin
                    if (accept) begin
                        fc_q <= fc_q + ADDR_W'(need);
                    end
                    pend_q <= pend_q + (accept ? CNT_W'(need) : '0) - ret_words_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfq_resp_filter.sv
module pfq_resp_filter
    import pfq_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int TAG_W  = DEF_TAG_W,
    parameter int QDEPTH = DEF_QDEPTH,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic                mem_rvalid_i,
    input  logic [2*WORD_W-1:0] mem_rdata_i,
    input  logic [TAG_W-1:0]    mem_rtag_i,
    input  logic [TAG_W-1:0]    epoch_i,
    input  disc_e               disc_i,
    input  logic                push_addr_lsb_i,
    output logic                push_lo_o,
    output logic                push_hi_o,
    output logic [WORD_W-1:0]   lo_word_o,
    output logic [WORD_W-1:0]   hi_word_o,
    output logic [CNT_W-1:0]    ret_words_o
);

    logic    live;
    fwidth_e width;

    assign live  = mem_rvalid_i && (mem_rtag_i == epoch_i) && (disc_i == DISC_NONE);
    assign width = width_for(push_addr_lsb_i);

    assign push_lo_o   = live;
    assign push_hi_o   = live && (width == FETCH_WIDE);
    assign lo_word_o   = mem_rdata_i[WORD_W-1:0];
    assign hi_word_o   = mem_rdata_i[2*WORD_W-1:WORD_W];
    assign ret_words_o = live ? CNT_W'(words_of(width)) : '0;

endmodule

// File: rtl/pfq_word_queue.sv
module pfq_word_queue
    import pfq_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int QDEPTH = DEF_QDEPTH,
    localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              push_lo_i,
    input  logic              push_hi_i,
    input  logic [WORD_W-1:0] lo_word_i,
    input  logic [WORD_W-1:0] hi_word_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [WORD_W-1:0] slot_q [QDEPTH];
    logic [PTR_W-1:0]  wr_q;
    logic [PTR_W-1:0]  rd_q;
    logic [PTR_W-1:0]  wr_next;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  push_n;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_next = bump(wr_q);
    assign push_n  = CNT_W'(push_lo_i) + CNT_W'(push_hi_i);
    assign head_o  = slot_q[rd_q];
    assign count_o = count_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < QDEPTH; i++) begin
            if (!clr_i && push_lo_i && wr_q == PTR_W'(i)) begin
                slot_q[i] <= lo_word_i;
            end else if (!clr_i && push_hi_i && wr_next == PTR_W'(i)) begin
                slot_q[i] <= hi_word_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push_hi_i) begin
                wr_q <= bump(wr_next);
            end else if (push_lo_i) begin
                wr_q <= wr_next;
            end
            if (pop_i) begin
                rd_q <= bump(rd_q);
            end
            count_q <= count_q + push_n - CNT_W'(pop_i);
        end
    end

endmodule

// File: rtl/ifetch_prefetch.sv
module ifetch_prefetch
    import pfq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int WORD_W = DEF_WORD_W,
    parameter int QDEPTH = DEF_QDEPTH,
    parameter int TAG_W  = DEF_TAG_W,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                redirect_i,
    input  logic [ADDR_W-1:0]   redirect_addr_i,
    input  logic                flush_i,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic                mem_wide_o,
    output logic [TAG_W-1:0]    mem_tag_o,
    input  logic                mem_ready_i,
    input  logic                mem_rvalid_i,
    input  logic [2*WORD_W-1:0] mem_rdata_i,
    input  logic [TAG_W-1:0]    mem_rtag_i,
    output logic                dec_valid_o,
    output logic [WORD_W-1:0]   dec_word_o,
    output logic [ADDR_W-1:0]   dec_addr_o,
    input  logic                dec_take_i
);

    disc_e             disc;
    logic [ADDR_W-1:0] dc_q;
    logic [ADDR_W-1:0] push_addr;
    logic [CNT_W-1:0]  q_count;
    logic [CNT_W-1:0]  pend;
    logic [CNT_W-1:0]  ret_words;
    logic [TAG_W-1:0]  epoch;
    logic              push_lo;
    logic              push_hi;
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;
    logic              pop;

    assign disc      = classify(redirect_i, flush_i);
    assign push_addr = dc_q + ADDR_W'(q_count);
    assign pop       = dec_take_i && dec_valid_o && (disc == DISC_NONE);

    assign dec_valid_o = (q_count != '0);
    assign dec_addr_o  = dc_q;
    assign mem_tag_o   = epoch;

    pfq_fetch_ctl #(
        .ADDR_W     (ADDR_W),
        .QDEPTH     (QDEPTH),
        .TAG_W      (TAG_W),
        .RESET_ADDR (RESET_ADDR)
    ) fetch_i (
        .clk         (clk),
        .rst         (rst),
        .disc_i      (disc),
        .target_i    (redirect_addr_i),
        .resume_i    (dc_q),
        .q_count_i   (q_count),
        .ret_words_i (ret_words),
        .mem_ready_i (mem_ready_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wide_o  (mem_wide_o),
        .epoch_o     (epoch),
        .pend_o      (pend)
    );

    pfq_resp_filter #(
        .WORD_W (WORD_W),
        .TAG_W  (TAG_W),
        .QDEPTH (QDEPTH)
    ) filt_i (
        .mem_rvalid_i    (mem_rvalid_i),
        .mem_rdata_i     (mem_rdata_i),
        .mem_rtag_i      (mem_rtag_i),
        .epoch_i         (epoch),
        .disc_i          (disc),
        .push_addr_lsb_i (push_addr[0]),
        .push_lo_o       (push_lo),
        .push_hi_o       (push_hi),
        .lo_word_o       (lo_word),
        .hi_word_o       (hi_word),
        .ret_words_o     (ret_words)
    );

    pfq_word_queue #(
        .WORD_W (WORD_W),
        .QDEPTH (QDEPTH)
    ) queue_i (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (disc != DISC_NONE),
        .push_lo_i (push_lo),
        .push_hi_i (push_hi),
        .lo_word_i (lo_word),
        .hi_word_i (hi_word),
        .pop_i     (pop),
        .head_o    (dec_word_o),
        .count_o   (q_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dc_q <= RESET_ADDR;
        end else if (disc == DISC_REDIRECT) begin
            dc_q <= redirect_addr_i;
        end else if (pop) begin
            dc_q <= dc_q + 1'b1;
        end
    end

endmodule

// File: rtl/ifetch_prefetch_chk.sv
module ifetch_prefetch_chk #(
    parameter int ADDR_W = 22,
    parameter int QDEPTH = 8,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              redirect_i,
    input logic              flush_i,
    input logic              mem_req_o,
    input logic              mem_ready_i,
    input logic              mem_wide_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              dec_valid_o,
    input logic              dec_take_i,
    input logic [ADDR_W-1:0] dec_addr_o,
    input logic [CNT_W-1:0]  q_count,
    input logic [CNT_W-1:0]  pend
);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (32'(q_count) + 32'(pend)) <= QDEPTH);

    assert_full_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (32'(q_count) == QDEPTH) |-> !mem_req_o);

    assert_wide_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_ready_i && mem_wide_o) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));

    assert_narrow_resume_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_ready_i && !mem_wide_o) |=>
            (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)) && !mem_addr_o[0]);

    assert_empty_after_disc_R5: assert property (@(posedge clk) disable iff (rst)
        (redirect_i || flush_i) |=> !dec_valid_o);

    assert_quiet_disc_R10: assert property (@(posedge clk) disable iff (rst)
        (redirect_i || flush_i) |-> !mem_req_o);

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && dec_take_i && !redirect_i && !flush_i) |=>
            (dec_addr_o == $past(dec_addr_o) + ADDR_W'(1)));

endmodule

bind ifetch_prefetch ifetch_prefetch_chk #(
    .ADDR_W (ADDR_W),
    .QDEPTH (QDEPTH)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .redirect_i  (redirect_i),
    .flush_i     (flush_i),
    .mem_req_o   (mem_req_o),
    .mem_ready_i (mem_ready_i),
    .mem_wide_o  (mem_wide_o),
    .mem_addr_o  (mem_addr_o),
    .dec_valid_o (dec_valid_o),
    .dec_take_i  (dec_take_i),
    .dec_addr_o  (dec_addr_o),
    .q_count     (q_count),
    .pend        (pend)
);

// File: tb/ifetch_prefetch_tb_top.sv
module ifetch_prefetch_tb_top;

    localparam int AW = 22;
    localparam int WW = 16;
    localparam int TW = 3;
    localparam int DEPTH = 8;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          redirect_i = 1'b0;
    logic [AW-1:0] redirect_addr_i = '0;
    logic          flush_i = 1'b0;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_wide_o;
    logic [TW-1:0] mem_tag_o;
    logic          mem_ready_i = 1'b0;
    logic          mem_rvalid_i = 1'b0;
    logic [2*WW-1:0] mem_rdata_i = '0;
    logic [TW-1:0] mem_rtag_i = '0;
    logic          dec_valid_o;
    logic [WW-1:0] dec_word_o;
    logic [AW-1:0] dec_addr_o;
    logic          dec_take_i = 1'b0;

    always #10 clk = ~clk;

    ifetch_prefetch dut_i (
        .clk             (clk),
        .rst             (rst),
        .redirect_i      (redirect_i),
        .redirect_addr_i (redirect_addr_i),
        .flush_i         (flush_i),
        .mem_req_o       (mem_req_o),
        .mem_addr_o      (mem_addr_o),
        .mem_wide_o      (mem_wide_o),
        .mem_tag_o       (mem_tag_o),
        .mem_ready_i     (mem_ready_i),
        .mem_rvalid_i    (mem_rvalid_i),
        .mem_rdata_i     (mem_rdata_i),
        .mem_rtag_i      (mem_rtag_i),
        .dec_valid_o     (dec_valid_o),
        .dec_word_o      (dec_word_o),
        .dec_addr_o      (dec_addr_o),
        .dec_take_i      (dec_take_i)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic          wide;
        logic [TW-1:0] tag;
        int            due;
        bit            live;
    } mem_op_t;

    mem_op_t       rq[$];
    int            vecs = 0;
    int            fails = 0;
    int            cyc = 0;
    int            last_due = 0;
    int            occ = 0;
    int            since_disc = 0;
    bit            prev_disc = 0;
    bit            after_flush = 0;
    logic [AW-1:0] exp_fc = '0;
    logic [AW-1:0] exp_addr = '0;

    bit            k_redir = 0;
    bit            k_flush = 0;
    logic [AW-1:0] k_tgt = '0;
    int            k_take = 1;
    bit            k_ready = 1;

    function automatic logic [WW-1:0] mw(input logic [AW-1:0] a);
        return WW'(a ^ (a >> 6)) ^ WW'(a * 7) ^ 16'hC3A5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        mem_op_t h;
        bit      have;
        bit      disc;
        bit      exp_req;
        int      pb;
        int      need;
        @(negedge clk);
        cyc++;
        disc = k_redir || k_flush;
        redirect_i      = k_redir;
        redirect_addr_i = k_tgt;
        flush_i         = k_flush;
        case (k_take)
            0:       dec_take_i = 1'b0;
            1:       dec_take_i = 1'b1;
            default: dec_take_i = (cyc % 3) != 0;
        endcase
        if (disc) dec_take_i = 1'b0;
        mem_ready_i = k_ready ? 1'b1 : ((cyc % 4) != 1);
        have = (rq.size() > 0) && (rq[0].due <= cyc);
        if (have) begin
            h = rq[0];
            mem_rvalid_i = 1'b1;
            mem_rtag_i   = h.tag;
            mem_rdata_i  = {h.wide ? mw(h.a + 1'b1) : 16'hDEAD, mw(h.a)};
        end else begin
            mem_rvalid_i = 1'b0;
            mem_rtag_i   = '0;
            mem_rdata_i  = '0;
        end
        #1;
        pb = 0;
        foreach (rq[i]) if (rq[i].live) pb += rq[i].wide ? 2 : 1;

        // R5 right after a discontinuity, R8 otherwise
        chk(dec_valid_o == (occ > 0), prev_disc ? "R5" : "R8", "dec_valid", dec_valid_o, occ > 0);

        need    = exp_fc[0] ? 1 : 2;
        exp_req = !disc && (occ + pb + need <= DEPTH);
        chk(mem_req_o == exp_req, disc ? "R10" : "R4", "mem_req", mem_req_o, exp_req);

        if (mem_req_o && mem_ready_i) begin
            chk(mem_addr_o == exp_fc, after_flush ? "R9" : (exp_fc[0] ? "R3" : "R2"),
                "fetch addr", mem_addr_o, exp_fc);
            chk(mem_wide_o == !exp_fc[0], exp_fc[0] ? "R3" : "R2", "fetch width", mem_wide_o, !exp_fc[0]);
            last_due = ((cyc + 1 + cyc % 3) > last_due + 1) ? (cyc + 1 + cyc % 3) : last_due + 1;
            rq.push_back('{a: mem_addr_o, wide: mem_wide_o, tag: mem_tag_o, due: last_due, live: 1'b1});
            exp_fc = exp_fc + (exp_fc[0] ? AW'(1) : AW'(2));
            after_flush = 0;
        end

        if (dec_valid_o && dec_take_i && occ > 0) begin
            chk(dec_addr_o == exp_addr, after_flush ? "R9" : "R8", "dec addr", dec_addr_o, exp_addr);
            chk(dec_word_o == mw(exp_addr), since_disc > 0 ? "R6" : "R7", "dec word", dec_word_o, mw(exp_addr));
            exp_addr = exp_addr + 1'b1;
            occ--;
        end

        if (have) begin
            void'(rq.pop_front());
            if (h.live && !disc) occ += h.wide ? 2 : 1;
        end

        if (disc) begin
            occ = 0;
            foreach (rq[i]) rq[i].live = 1'b0;
            since_disc = 6;
            prev_disc  = 1;
            if (k_redir) begin
                exp_fc      = k_tgt;
                exp_addr    = k_tgt;
                after_flush = 0;
            end else begin
                exp_fc      = exp_addr;
                after_flush = 1;
            end
        end else begin
            prev_disc = 0;
            if (since_disc > 0) since_disc--;
        end
        k_redir = 0;
        k_flush = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_redirect(input logic [AW-1:0] t);
        k_redir = 1;
        k_tgt   = t;
        step();
    endtask

    task automatic do_flush();
        k_flush = 1;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: quiet while in reset
        chk(mem_req_o == 1'b0, "R1", "req in reset", mem_req_o, 0);
        chk(dec_valid_o == 1'b0, "R1", "valid in reset", dec_valid_o, 0);
        rst = 1'b0;
        #1;
        chk(mem_addr_o == '0, "R1", "reset fetch addr", mem_addr_o, 0);
        chk(dec_valid_o == 1'b0, "R1", "empty after reset", dec_valid_o, 0);

        k_take = 1; k_ready = 1;
        run(40);
        k_take = 0;                 // fill the queue: R4 stall
        run(25);
        k_take = 1;
        run(10);
        do_redirect(22'h001001);    // odd target: R3
        run(30);
        k_take = 2; k_ready = 0;
        run(60);
        do_flush();                 // R9 with reads in flight: R6
        run(20);
        run(3);
        do_flush();
        run(20);
        do_redirect(22'h3FFFFF);    // odd at top of space, wraps to 0
        run(20);
        k_take = 0;
        do_redirect(22'h000010);
        run(3);
        do_flush();
        run(15);
        k_take = 2;
        do_redirect(22'h000055);
        run(5);
        do_flush();
        run(12);
        k_redir = 1; k_flush = 1; k_tgt = 22'h000777;   // R10 priority
        step();
        run(25);
        do_redirect(22'h000100);
        do_redirect(22'h000205);
        run(30);
        k_take = 1; k_ready = 1;
        run(40);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule